// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block produces the vertical timing of a display pipe whose frame length may change from one frame to the next. A per-line tick advances a scanline counter. From that counter the block drives the active-region, blanking, sync and frame-start outputs. It also issues a one-cycle latch pulse that marks where the frame's tail begins (the delayed blanking start). At that pulse, software-visible configuration becomes the timing for the following frame.

The tail can begin anywhere between an early and a late decision line. In variable mode, software moves it forward by writing a send request to the push register. Without a request, the frame runs to its longest length. When variable mode is off, or when min, max and flip line are equal, the block is an ordinary fixed-refresh generator.

Configuration is written through a plain write strobe with an address and a data word. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure. Every write is accepted in the cycle its strobe is high.

Top module: `vrr_vtg`

## Requirements
- R1: Addresses are 0 active lines, 1 min length, 2 max length, 3 flip line, 4 tail length (guard), 5 sync start offset, 6 sync end offset, 7 control, 8 push. Addresses 1 to 3 hold the line count minus one. With min, max and flip line equal to V-1 and variable mode off, every frame is V lines long.
- R2: With variable mode live and no send request, the tail begins at line (max+1)-guard.
- R3: A send request written before the early decision line is held pending. The tail then begins exactly at the early line, which is max(min+1, flip+1)-guard.
- R4: A send request written while the counter is inside the decision window starts the tail on the next line.
- R5: Control bit 1 enables the flip line. When it is clear, the early line is (min+1)-guard.
- R6: Push bit 0 is enable and bit 1 is send. Send is set only together with enable. It clears itself in the cycle the tail starts while variable mode is live. When variable mode is not live, a request is neither consumed nor able to shorten the frame. Writing push with bit 0 clear drops the request.
- R7: Control bit 0 enables variable mode. The live status output changes only at a frame boundary. After the enable is cleared, status stays high until the frame in which the change was latched has ended.
- R8: The blank output is high from the tail's first line to the frame's last line. The frame lasts tail-start plus guard lines. The active output is high while the line is below the active-lines value.
- R9: Sync is high on lines whose distance to the frame end is at most the sync start offset and greater than the sync end offset.
- R10: Registers 0 to 7 are shadowed. Their live copies change only when the tail starts, and the latch output is a one-cycle pulse at that moment.
- R11: The line output returns to zero on the tick after the frame's last line. The frame-start output pulses for one clock at that tick, and the line output holds steady between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | DW | Register write data |
| line_o | output | LW | Current scanline |
| vactive | output | 1 | Active region |
| vblank | output | 1 | Delayed blanking (frame tail) |
| vsync | output | 1 | Vertical sync |
| frame_start | output | 1 | One-clock pulse when a frame begins |
| latch_pulse | output | 1 | One-clock pulse when shadows are copied to live |
| vrr_live | output | 1 | Variable mode is live for this frame |
| push_pending | output | 1 | Send request outstanding |

## Verification
The tail-start decision does several things in one cycle: it copies the shadowed configuration, consumes a pending send request and fixes the length of the current frame. The bench provokes all of them at once. In one frame it writes a disable to the control shadow and posts a send request, and both are taken at the same early-line decision. The judgement has three parts: that frame must still end early, the request bit must clear on that edge, and the live status must fall only at the following frame start. In the next frame the bench checks that a new request is ignored and left pending.

// File: rtl/vrr_vtg_pkg.sv
package vrr_vtg_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_FIELDS = 7;

  // field index equals its register address
  typedef enum logic [ADDR_W-1:0] {
    RA_ACTIVE = 4'd0,
    RA_MINLEN = 4'd1,
    RA_MAXLEN = 4'd2,
    RA_FLIP   = 4'd3,
    RA_GUARD  = 4'd4,
    RA_SYNC_S = 4'd5,
    RA_SYNC_E = 4'd6,
    RA_CTRL   = 4'd7,
    RA_PUSH   = 4'd8
  } reg_addr_e;

  localparam int CTRL_VAR_BIT  = 0;
  localparam int CTRL_FLIP_BIT = 1;
  localparam int PUSH_EN_BIT   = 0;
  localparam int PUSH_SEND_BIT = 1;
endpackage

// File: rtl/vrr_cfg_regs.sv
module vrr_cfg_regs
  import vrr_vtg_pkg::*;
#(
  parameter int LW = 12,
  parameter int DW = 16,
  parameter int RST_ACTIVE = 4,
  parameter int RST_LEN_M1 = 9,
  parameter int RST_GUARD = 3,
  parameter int RST_SYNC_S = 2,
  parameter int RST_SYNC_E = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           latch,
  input  logic                           consume,
  output logic [NUM_FIELDS-1:0][LW-1:0]  live_fields,
  output logic                           var_en_live,
  output logic                           flip_en_live,
  output logic                           push_en,
  output logic                           push_send
);
  localparam logic [LW-1:0] RST_VAL [NUM_FIELDS] = '{
    LW'(RST_ACTIVE), LW'(RST_LEN_M1), LW'(RST_LEN_M1), LW'(RST_LEN_M1),
    LW'(RST_GUARD), LW'(RST_SYNC_S), LW'(RST_SYNC_E)
  };

  logic [NUM_FIELDS-1:0][LW-1:0] shadow;
  logic [1:0] ctrl_shadow, ctrl_live;
  logic wr_push, wr_ctrl;

  assign wr_push = wr_en && (wr_addr == RA_PUSH);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i]      <= RST_VAL[i];
        live_fields[i] <= RST_VAL[i];
      end else begin
        if (wr_en && wr_addr == ADDR_W'(i)) shadow[i] <= wr_data[LW-1:0];
        if (latch) live_fields[i] <= shadow[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_shadow <= '0;
      ctrl_live   <= '0;
    end else begin
      if (wr_ctrl) ctrl_shadow <= wr_data[1:0];
      if (latch) ctrl_live <= ctrl_shadow;
    end
  end

  assign var_en_live  = ctrl_live[CTRL_VAR_BIT];
  assign flip_en_live = ctrl_live[CTRL_FLIP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_en   <= 1'b0;
      push_send <= 1'b0;
    end else if (wr_push) begin
      push_en   <= wr_data[PUSH_EN_BIT];
      push_send <= wr_data[PUSH_EN_BIT] &
                   (wr_data[PUSH_SEND_BIT] | (push_send & ~consume));
    end else if (consume) begin
      push_send <= 1'b0;
    end
  end
endmodule

// File: rtl/vrr_line_ctr.sv
module vrr_line_ctr #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [LW-1:0] min_m1,
  input  logic [LW-1:0] max_m1,
  input  logic [LW-1:0] flip_m1,
  input  logic [LW-1:0] guard,
  input  logic          flip_en,
  input  logic          var_en,
  input  logic          push_req,
  output logic [LW-1:0] line_q,
  output logic          tail_q,
  output logic [LW:0]   end_q,
  output logic          decide,
  output logic          latch_q,
  output logic          fs_q,
  output logic          live_q
);
  localparam int CW = LW + 1;

  logic [CW-1:0] nxt, min_t, max_t, flip_t, early_t, b_early, b_late;
  logic wrap;

  assign nxt     = CW'(line_q) + CW'(1);
  assign min_t   = CW'(min_m1) + CW'(1);
  assign max_t   = CW'(max_m1) + CW'(1);
  assign flip_t  = CW'(flip_m1) + CW'(1);
  assign early_t = (flip_en && flip_t > min_t) ? flip_t : min_t;
  assign b_early = early_t - CW'(guard);
  assign b_late  = max_t - CW'(guard);

  assign decide = tick && !tail_q &&
                  (nxt >= b_late || (push_req && nxt >= b_early));
  assign wrap   = tick && tail_q && nxt >= end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      tail_q  <= 1'b0;
      end_q   <= '0;
      latch_q <= 1'b0;
      fs_q    <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      latch_q <= decide;
      fs_q    <= wrap;
      if (wrap) begin
        line_q <= '0;
        tail_q <= 1'b0;
        live_q <= var_en;
      end else if (tick) begin
        line_q <= line_q + LW'(1);
      end
      if (decide) begin
        tail_q <= 1'b1;
        end_q  <= nxt + CW'(guard);
      end
    end
  end
endmodule

// File: rtl/vrr_out_dec.sv
module vrr_out_dec #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          decide,
  input  logic [LW-1:0] sync_s,
  input  logic [LW-1:0] sync_e,
  input  logic [LW-1:0] active_lines,
  input  logic [LW-1:0] line_q,
  input  logic          tail_q,
  input  logic [LW:0]   end_q,
  output logic          vactive,
  output logic          vblank,
  output logic          vsync
);
  logic [LW-1:0] ss_q, se_q;
  logic [LW:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= '0;
      se_q <= '0;
    end else if (decide) begin
      ss_q <= sync_s;
      se_q <= sync_e;
    end
  end

  assign remain  = end_q - (LW+1)'(line_q);
  assign vactive = line_q < active_lines;
  assign vblank  = tail_q;
  assign vsync   = tail_q && remain <= (LW+1)'(ss_q) && remain > (LW+1)'(se_q);
endmodule

// File: rtl/vrr_vtg.sv
module vrr_vtg
  import vrr_vtg_pkg::*;
#(
  parameter int LW = 12,
  parameter int DW = 16,
  parameter int RST_ACTIVE = 4,
  parameter int RST_LEN_M1 = 9,
  parameter int RST_GUARD = 3,
  parameter int RST_SYNC_S = 2,
  parameter int RST_SYNC_E = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [LW-1:0]     line_o,
  output logic              vactive,
  output logic              vblank,
  output logic              vsync,
  output logic              frame_start,
  output logic              latch_pulse,
  output logic              vrr_live,
  output logic              push_pending
);
  logic [NUM_FIELDS-1:0][LW-1:0] fld;
  logic var_en, flip_en, push_en, push_send, push_req, decide, tail;
  logic [LW:0] end_line;

  assign push_req     = vrr_live & push_en & push_send;
  assign push_pending = push_send;

  vrr_cfg_regs #(
    .LW(LW), .DW(DW), .RST_ACTIVE(RST_ACTIVE), .RST_LEN_M1(RST_LEN_M1),
    .RST_GUARD(RST_GUARD), .RST_SYNC_S(RST_SYNC_S), .RST_SYNC_E(RST_SYNC_E)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .latch(decide), .consume(decide & push_req),
    .live_fields(fld), .var_en_live(var_en), .flip_en_live(flip_en),
    .push_en(push_en), .push_send(push_send)
  );

  vrr_line_ctr #(.LW(LW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(line_tick),
    .min_m1(fld[RA_MINLEN]), .max_m1(fld[RA_MAXLEN]), .flip_m1(fld[RA_FLIP]),
    .guard(fld[RA_GUARD]), .flip_en(flip_en), .var_en(var_en),
    .push_req(push_req), .line_q(line_o), .tail_q(tail), .end_q(end_line),
    .decide(decide), .latch_q(latch_pulse), .fs_q(frame_start),
    .live_q(vrr_live)
  );

  vrr_out_dec #(.LW(LW)) u_dec (
    .clk(clk), .rst_n(rst_n), .decide(decide),
    .sync_s(fld[RA_SYNC_S]), .sync_e(fld[RA_SYNC_E]),
    .active_lines(fld[RA_ACTIVE]), .line_q(line_o), .tail_q(tail),
    .end_q(end_line), .vactive(vactive), .vblank(vblank), .vsync(vsync)
  );
endmodule

// File: rtl/vrr_vtg_chk.sv
module vrr_vtg_chk #(
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_tick,
  input logic          cfg_wr_en,
  input logic [LW-1:0] line_o,
  input logic          vactive,
  input logic          vblank,
  input logic          vsync,
  input logic          frame_start,
  input logic          latch_pulse,
  input logic          vrr_live,
  input logic          push_pending
);
  // R10
  latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> !latch_pulse);
  // R11
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_o == '0);
  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(line_o));
  // R9
  sync_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> vblank);
  // R8
  active_not_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vactive |-> !vblank);
  // R7
  live_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vrr_live) |-> frame_start);
  // R6
  send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(push_pending) && !$past(cfg_wr_en)) |-> latch_pulse);
endmodule

bind vrr_vtg vrr_vtg_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cfg_wr_en(cfg_wr_en),
  .line_o(line_o), .vactive(vactive), .vblank(vblank), .vsync(vsync),
  .frame_start(frame_start), .latch_pulse(latch_pulse),
  .vrr_live(vrr_live), .push_pending(push_pending)
);

// File: tb/vrr_vtg_tb.sv
module vrr_vtg_tb;
  localparam int LW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [LW-1:0] line_o;
  logic vactive, vblank, vsync, frame_start, latch_pulse, vrr_live, push_pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { int dl; int vt; } exp_t;
  exp_t q[$];

  vrr_vtg u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .line_o(line_o),
    .vactive(vactive), .vblank(vblank), .vsync(vsync),
    .frame_start(frame_start), .latch_pulse(latch_pulse),
    .vrr_live(vrr_live), .push_pending(push_pending)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    cfg_wr_en = 1'b1;
    cfg_addr  = 4'(a);
    cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_line(input int k);
    do @(negedge clk); while (int'(line_o) != k);
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic expect_frame(input int dl, input int vt);
    exp_t e;
    e.dl = dl;
    e.vt = vt;
    q.push_back(e);
  endtask

  // line tick every four clocks
  initial begin
    @(posedge rst_n);
    forever begin
      repeat (3) @(negedge clk);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
    end
  end

  // monitor: tail start line and frame length against the queue
  int prev_line = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (latch_pulse) begin
        if (q.size() == 0) chk(1'b0, "R10 unexpected latch", int'(line_o), -1);
        else chk(int'(line_o) == q[0].dl, "R2/R3/R4 tail start line", int'(line_o), q[0].dl);
      end
      if (frame_start) begin
        if (q.size() == 0) chk(1'b0, "R11 unexpected frame", prev_line + 1, -1);
        else begin
          chk(prev_line + 1 == q[0].vt, "R8 frame length", prev_line + 1, q[0].vt);
          void'(q.pop_front());
        end
      end
      prev_line = int'(line_o);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_o == 0, "R11 reset line", int'(line_o), 0);
    chk(vactive == 1'b1, "R8 reset active", int'(vactive), 1);
    chk(vblank == 1'b0, "R8 reset blank", int'(vblank), 0);
    chk(vrr_live == 1'b0, "R7 reset live", int'(vrr_live), 0);
    chk(push_pending == 1'b0, "R6 reset push", int'(push_pending), 0);

    // F1 fixed 10 lines (R1); new config shadowed (R10)
    expect_frame(7, 10);
    expect_frame(17, 20);
    expect_frame(9, 12);
    wait_line(1);
    wr(1, 9); wr(2, 19); wr(3, 11); wr(4, 3);
    wr(5, 2); wr(6, 0); wr(0, 4); wr(7, 3);

    // F2: live, no push -> late line (R2); sync/blank/active decode
    wait_fs();
    chk(vrr_live == 1'b1, "R7 live rises at boundary", int'(vrr_live), 1);
    wait_line(3);
    chk(vactive == 1'b1, "R8 active line 3", int'(vactive), 1);
    wait_line(4);
    chk(vactive == 1'b0 && vblank == 1'b0, "R8 gap line 4", int'(vactive), 0);
    wait_line(16);
    chk(vblank == 1'b0, "R2 no tail at 16", int'(vblank), 0);
    wait_line(17);
    chk(vblank == 1'b1, "R8 tail at 17", int'(vblank), 1);
    chk(vsync == 1'b0, "R9 sync off at 17", int'(vsync), 0);
    wait_line(18);
    chk(vsync == 1'b1, "R9 sync on at 18", int'(vsync), 1);
    wait_line(19);
    chk(vsync == 1'b1, "R9 sync on at 19", int'(vsync), 1);

    // F3: early push held to early line (R3)
    wait_fs();
    chk(vsync == 1'b0, "R9 sync off at line 0", int'(vsync), 0);
    expect_frame(14, 17);
    wait_line(1);
    wr(8, 3);
    chk(push_pending == 1'b1, "R6 send set", int'(push_pending), 1);
    wait_line(8);
    chk(vblank == 1'b0 && push_pending == 1'b1, "R3 held before early line", int'(vblank), 0);
    wait_line(9);
    chk(vblank == 1'b1, "R3 tail at early line", int'(vblank), 1);
    chk(push_pending == 1'b0, "R6 send self clears", int'(push_pending), 0);

    // F4: flip disable shadowed; push mid-window (R4)
    wait_fs();
    expect_frame(7, 10);
    wait_line(1);
    wr(7, 1);
    wait_line(13);
    wr(8, 3);
    wait_line(14);
    chk(vblank == 1'b1, "R4 tail on next line", int'(vblank), 1);

    // F5: early line from min only (R5); disable latched with push (R7)
    wait_fs();
    expect_frame(17, 20);
    wait_line(1);
    wr(7, 0);
    wr(8, 3);
    wait_line(7);
    chk(vblank == 1'b1, "R5 early line from min", int'(vblank), 1);
    chk(vrr_live == 1'b1, "R7 live held in frame", int'(vrr_live), 1);

    // F6: not live, push ignored and kept (R6)
    wait_fs();
    chk(vrr_live == 1'b0, "R7 live drops at boundary", int'(vrr_live), 0);
    wait_line(1);
    wr(8, 3);
    wait_line(18);
    chk(push_pending == 1'b1, "R6 push kept when not live", int'(push_pending), 1);
    wr(8, 0);
    chk(push_pending == 1'b0, "R6 push dropped by enable clear", int'(push_pending), 0);
    wait_fs();
    @(negedge clk);
    chk(q.size() == 0, "R11 all frames seen", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule